// File: doc/BRIEF.md
# Refresh Deadline and Activate Lockout Scheduler

This block sits beside the command arbiter of a DDR3 memory controller once initialization is done. It counts the clocks since the most recent refresh command and asks for a refresh before the refresh interval runs out. It has two levels of request: a plain request that the arbiter may serve when the bus is idle, and an urgent flag for when the deadline is close. It also keeps row activates from being issued while the device is still recovering from a refresh.

A refresh that answers a request starts a burst of several refresh commands. The request stays asserted until the whole burst has been issued. A refresh issued early, while no request is pending, restarts the interval on its own and does not start a burst. The interval, the recovery time, the two warning margins and the burst length are all parameters counted in clocks. The defaults are a 1560-clock interval (7.8 µs at 200 MHz), 320 clocks of recovery, a 256-clock request margin, a 64-clock urgent margin and a burst of 4.

The arbiter drives `opEnable` high when the controller becomes operational. It pulses `refIssued` for one clock each time it puts a refresh command on the bus.

Top module: `refresh_scheduler`

## Requirements
- R1: While `opEnable` is low, `refReq`, `refUrgent` and `actAllowed` are all low. The clock count is held at zero.
- R2: After `opEnable` rises, `actAllowed` stays low until RECOVERY (320) rising clock edges have been sampled with `opEnable` high. It is high from then on.
- R3: In any cycle where `refIssued` is high, `actAllowed` is low. After the edge that samples the strobe, `actAllowed` stays low until RECOVERY further edges have passed, and then it rises.
- R4: `refReq` rises once the count of clocks since the last refresh, or since enable, reaches INTERVAL−REQ_MARGIN (1304). It is low below that count.
- R5: `refUrgent` is high exactly while that count is at least INTERVAL−URG_MARGIN (1496). A refresh strobe clears it at the edge that samples the strobe.
- R6: A burst begins with a refresh strobe issued while `refReq` is high. `refReq` then stays high through the first BURST−1 (3) strobes and falls at the edge that samples strobe number BURST (4).
- R7: A refresh strobe issued while `refReq` is low restarts the interval count from zero. It leaves `refReq` low, and the next request comes INTERVAL−REQ_MARGIN clocks after that strobe.
- R8: Dropping `opEnable` forces every output low in the same cycle and abandons any burst in progress. After enable returns, timing restarts as in R2 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| opEnable | input | 1 | High once initialization is complete |
| refIssued | input | 1 | One-clock strobe when a refresh command is issued |
| refReq | output | 1 | Refresh wanted, or a burst not yet finished |
| refUrgent | output | 1 | Refresh deadline is near |
| actAllowed | output | 1 | Row activates may be issued |

## Verification
The assertions assume that the arbiter always answers in time. The interval count must never reach INTERVAL while the block is enabled, so every burst has to start before the deadline. They also take `refIssued` to be a strobe that the arbiter asserts only while `opEnable` is high. The bench starts each burst within a few clocks of `refUrgent` rising and spaces the burst strobes a few clocks apart. It pulses the refresh strobe only at points where the interval count is well below its limit.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  // strobes from control to the interval counter
  typedef struct packed {
    logic clr;
    logic inc;
  } cntCtl_t;

  // threshold status from the interval counter
  typedef struct packed {
    logic reqHit;
    logic urgHit;
    logic recDone;
  } cntSts_t;

endpackage

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int INTERVAL   = 1560,
  parameter int RECOVERY   = 320,
  parameter int REQ_MARGIN = 256,
  parameter int URG_MARGIN = 64
) (
  input  logic    clk,
  input  logic    rst,
  input  cntCtl_t ctl,
  output cntSts_t sts
);

  localparam int CW     = $clog2(INTERVAL + 1);
  localparam int REQ_TH = INTERVAL - REQ_MARGIN;
  localparam int URG_TH = INTERVAL - URG_MARGIN;

  logic [CW-1:0] sinceCnt;

  always_ff @(posedge clk) begin
    if (rst || ctl.clr) begin
      sinceCnt <= '0;
    end else if (ctl.inc && (sinceCnt != CW'(INTERVAL))) begin
      sinceCnt <= sinceCnt + CW'(1);
    end
  end

  always_comb begin
    sts.reqHit  = (sinceCnt >= CW'(REQ_TH));
    sts.urgHit  = (sinceCnt >= CW'(URG_TH));
    sts.recDone = (sinceCnt >= CW'(RECOVERY));
  end

  // R5: the arbiter is assumed to refresh before the interval expires
  a_r5_deadline_met: assert property (@(posedge clk) disable iff (rst)
    sinceCnt != CW'(INTERVAL));

  // R3: a clear strobe from control restarts the count
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
    ctl.clr |=> (sinceCnt == '0));

endmodule

// File: rtl/refsched_ctl.sv
module refsched_ctl
  import refsched_pkg::*;
#(
  parameter int BURST = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    opEnable,
  input  logic    refIssued,
  input  cntSts_t sts,
  output cntCtl_t ctl,
  output logic    refReq,
  output logic    refUrgent,
  output logic    actAllowed
);

  localparam int BW = (BURST > 1) ? $clog2(BURST) : 1;
  localparam logic [BW-1:0] LAST = BW'(BURST - 1);

  logic [BW-1:0] burstCnt;

  always_comb begin
    ctl.clr    = !opEnable || refIssued;
    ctl.inc    = opEnable;
    refReq     = opEnable && (sts.reqHit || (burstCnt != '0));
    refUrgent  = opEnable && sts.urgHit;
    actAllowed = opEnable && sts.recDone && !refIssued;
  end

  always_ff @(posedge clk) begin
    if (rst || !opEnable) begin
      burstCnt <= '0;
    end else if (refIssued && refReq) begin
      burstCnt <= (burstCnt == LAST) ? '0 : burstCnt + BW'(1);
    end
  end

  // R1: idle means every flag is low
  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    !opEnable |-> (!refReq && !refUrgent && !actAllowed));

  // R3: no activate in a refresh cycle
  a_r3_strobe_blocks: assert property (@(posedge clk) disable iff (rst)
    refIssued |-> !actAllowed);

  // R5: urgency is a stronger form of the request
  a_r5_urgent_has_req: assert property (@(posedge clk) disable iff (rst)
    refUrgent |-> refReq);

  // R6: request holds until a strobe arrives
  a_r6_req_holds: assert property (@(posedge clk) disable iff (rst)
    (opEnable && refReq && !refIssued) |=> (!opEnable || refReq));

  // R6: final strobe of a burst clears the request
  a_r6_burst_end: assert property (@(posedge clk) disable iff (rst)
    (opEnable && refReq && refIssued && (burstCnt == LAST)) |=> !refReq);

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refsched_pkg::*;
#(
  parameter int INTERVAL   = 1560,
  parameter int RECOVERY   = 320,
  parameter int REQ_MARGIN = 256,
  parameter int URG_MARGIN = 64,
  parameter int BURST      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic opEnable,
  input  logic refIssued,
  output logic refReq,
  output logic refUrgent,
  output logic actAllowed
);

  cntCtl_t cntCtl;
  cntSts_t cntSts;

  refsched_dp #(
    .INTERVAL  (INTERVAL),
    .RECOVERY  (RECOVERY),
    .REQ_MARGIN(REQ_MARGIN),
    .URG_MARGIN(URG_MARGIN)
  ) i_dp (
    .clk(clk),
    .rst(rst),
    .ctl(cntCtl),
    .sts(cntSts)
  );

  refsched_ctl #(
    .BURST(BURST)
  ) i_ctl (
    .clk       (clk),
    .rst       (rst),
    .opEnable  (opEnable),
    .refIssued (refIssued),
    .sts       (cntSts),
    .ctl       (cntCtl),
    .refReq    (refReq),
    .refUrgent (refUrgent),
    .actAllowed(actAllowed)
  );

endmodule

// File: tb/test_refresh_scheduler.sv
`timescale 1ns/1ps
module test_refresh_scheduler;

  localparam int REQ_TH = 1304;
  localparam int URG_TH = 1496;
  localparam int REC    = 320;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic opEnable = 1'b0;
  logic refIssued = 1'b0;
  logic refReq, refUrgent, actAllowed;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  refresh_scheduler i_refresh_scheduler (
    .clk(clk), .rst(rst), .opEnable(opEnable), .refIssued(refIssued),
    .refReq(refReq), .refUrgent(refUrgent), .actAllowed(actAllowed)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic strobe();
    refIssued = 1'b1;
    #1;
    chk("R3", "actAllowed during strobe", actAllowed, 1'b0);
    step(1);
    refIssued = 1'b0;
    #1;
  endtask

  task automatic restart();
    opEnable = 1'b0;
    step(1);
    opEnable = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    chk("R1", "refReq in reset", refReq, 1'b0);
    chk("R1", "refUrgent in reset", refUrgent, 1'b0);
    chk("R1", "actAllowed in reset", actAllowed, 1'b0);
    rst = 1'b0;
    step(5);
    chk("R1", "refReq idle", refReq, 1'b0);
    chk("R1", "actAllowed idle", actAllowed, 1'b0);
  endtask

  task automatic t_enable_recovery();
    restart();
    step(REC - 1);
    chk("R2", "actAllowed before recovery", actAllowed, 1'b0);
    step(1);
    chk("R2", "actAllowed at recovery", actAllowed, 1'b1);
  endtask

  task automatic t_deadline_burst();
    restart();
    step(REQ_TH - 1);
    chk("R4", "refReq one before threshold", refReq, 1'b0);
    step(1);
    chk("R4", "refReq at threshold", refReq, 1'b1);
    chk("R5", "refUrgent at request threshold", refUrgent, 1'b0);
    step(URG_TH - REQ_TH - 1);
    chk("R5", "refUrgent one before", refUrgent, 1'b0);
    step(1);
    chk("R5", "refUrgent at threshold", refUrgent, 1'b1);
    step(2);
    strobe();
    chk("R5", "refUrgent after strobe", refUrgent, 1'b0);
    chk("R6", "refReq after 1st strobe", refReq, 1'b1);
    chk("R3", "actAllowed after strobe", actAllowed, 1'b0);
    step(5);
    strobe();
    chk("R6", "refReq after 2nd strobe", refReq, 1'b1);
    step(5);
    strobe();
    chk("R6", "refReq after 3rd strobe", refReq, 1'b1);
    step(5);
    strobe();
    chk("R6", "refReq after 4th strobe", refReq, 1'b0);
    step(REC - 1);
    chk("R3", "actAllowed before recovery", actAllowed, 1'b0);
    step(1);
    chk("R3", "actAllowed after recovery", actAllowed, 1'b1);
  endtask

  task automatic t_early_refresh();
    restart();
    step(500);
    chk("R2", "actAllowed mid interval", actAllowed, 1'b1);
    strobe();
    chk("R7", "refReq after early strobe", refReq, 1'b0);
    step(REC - 1);
    chk("R3", "actAllowed before recovery (early)", actAllowed, 1'b0);
    step(1);
    chk("R3", "actAllowed after recovery (early)", actAllowed, 1'b1);
    step(REQ_TH - REC - 1);
    chk("R7", "refReq one before restarted threshold", refReq, 1'b0);
    step(1);
    chk("R7", "refReq at restarted threshold", refReq, 1'b1);
  endtask

  task automatic t_disable();
    // refReq high from the previous scenario; start a burst then drop enable
    strobe();
    chk("R6", "refReq mid burst", refReq, 1'b1);
    opEnable = 1'b0;
    #1;
    chk("R8", "refReq on disable", refReq, 1'b0);
    chk("R8", "refUrgent on disable", refUrgent, 1'b0);
    chk("R8", "actAllowed on disable", actAllowed, 1'b0);
    step(3);
    chk("R1", "refReq while disabled", refReq, 1'b0);
    opEnable = 1'b1;
    #1;
    step(1);
    chk("R8", "refReq after re-enable (burst dropped)", refReq, 1'b0);
    chk("R8", "actAllowed after re-enable", actAllowed, 1'b0);
    step(REC - 2);
    chk("R8", "actAllowed before recovery", actAllowed, 1'b0);
    step(1);
    chk("R8", "actAllowed at recovery", actAllowed, 1'b1);
    step(REQ_TH - REC - 1);
    chk("R8", "refReq one before threshold", refReq, 1'b0);
    step(1);
    chk("R8", "refReq at threshold", refReq, 1'b1);
    opEnable = 1'b0;
    #1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    t_enable_recovery();
    t_deadline_burst();
    t_early_refresh();
    t_disable();
    step(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule